// File: doc/BRIEF.md
# Rotating Multilevel PWM Serializer

This block turns a stream of nine-level quantizer codes from a noise-shaped modulator into a one-bit pulse stream. Time is cut into frames of eight master-clock cycles. Each frame carries as many ones as the code it was loaded with, from zero to eight. One output bit leaves the block on every master-clock cycle. With a 22.5792 MHz or 24.576 MHz master clock this is the 512-times single-bit audio rate. The block raises a frame strobe on the last clock of every frame. The modulator presents its next code during that cycle.

Two mode inputs shape the pattern. The restrict input limits the quantizer to seven of its nine levels. Every frame then holds at least one one and at least one zero. The rotate input turns on a pseudo-random cyclic rotation of the pulse inside the frame. A 16-bit maximal-length LFSR supplies this rotation. With rotation off, the pulse is a plain run of ones starting at the first clock of the frame. With rotation off and restrict on, each frame has exactly one rising and one falling edge. The edge density therefore does not depend on the signal.

The frame position is an eight-state machine with the states PH_0 to PH_7. Each state moves unconditionally to the next state: PH_0 to PH_1, PH_1 to PH_2, and so on up to PH_6 to PH_7. The wrap transition PH_7 to PH_0 loads the code, latches the modes, advances the LFSR and sets the new rotation offset. The frame strobe is high in PH_7 only.

Top module: `rpwm_serializer`

## Requirements
- R1: While `rst_n` is low and right after it rises, `bit_out` is 0 and `frame_strobe` is 0. The first frame after reset has level 0 and offset 0. Its strobe appears on the eighth clock cycle after reset release.
- R2: `frame_strobe` is high on exactly one cycle in every eight, which is the last cycle of each frame.
- R3: `code` is sampled only at the clock edge that ends a strobe cycle, and only when `code_valid` is 1. It sets the level of the following frame. That frame carries exactly that many ones for codes 0..8. Codes 9..15 act as 8. Code and mode values on other cycles have no effect.
- R4: If `code_valid` is 0 at the end of a strobe cycle, the next frame repeats the previous level.
- R5: `restrict_en` is latched together with an accepted code. When it is 1, code 0 becomes level 1, and codes 8..15 become level 7. Codes 1..7 are kept as they are.
- R6: When the latched rotate mode is 0, the ones of a frame form one contiguous run starting at the first cycle of the frame (position 0).
- R7: `rotate_en` is latched at every frame boundary. The LFSR resets to 16'hACE1 and shifts once per frame boundary toward its MSB. The new bit 0 is the XOR of bits 15, 13, 12 and 10. When rotation is latched on, the frame offset is bits [2:0] of the advanced LFSR value; otherwise the offset is 0. The bit at position p is 1 exactly when ((p - offset) mod 8) is less than the level.
- R8: With restrict and no rotation latched, position 0 of each frame is 1 and position 7 is 0. This gives one rising and one falling edge per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, one output bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_valid | input | 1 | Code qualifier, used only in strobe cycles |
| code | input | 4 | Quantizer code, 0..8 meaningful |
| restrict_en | input | 1 | 1 selects seven-of-nine levels |
| rotate_en | input | 1 | 1 enables random pulse rotation |
| bit_out | output | 1 | Serial pulse stream |
| frame_strobe | output | 1 | High on the last cycle of each frame |

## Verification
A corrupted phase state shows at once as a strobe on the wrong cycle, or as a run of ones that no longer starts at position 0, within one frame. A wrong level register shows at the end of the frame as a wrong count of ones. A wrong LFSR state or tap set shows as a rotated pattern at the wrong offset. This appears in the first frame after the damage where the offset bits differ, usually within a few frames. Mode latching faults show as broken edge rules in restricted no-rotation frames.

// File: rtl/rpwm_pkg.sv
package rpwm_pkg;
    localparam int FRAME_LEN = 8;
    localparam int POS_W     = $clog2(FRAME_LEN);
    localparam int LVL_W     = 4;
    localparam int LVL_MAX   = FRAME_LEN;

    typedef enum logic [POS_W-1:0] {
        PH_0, PH_1, PH_2, PH_3, PH_4, PH_5, PH_6, PH_7
    } phase_t;

    typedef logic [LVL_W-1:0] level_t;

    function automatic level_t clamp_level(input level_t raw, input logic restrict_mode);
        level_t lv;
        lv = (raw > level_t'(LVL_MAX)) ? level_t'(LVL_MAX) : raw;
        if (restrict_mode) begin
            if (lv == '0)
                lv = level_t'(1);
            else if (lv == level_t'(LVL_MAX))
                lv = level_t'(LVL_MAX - 1);
        end
        return lv;
    endfunction
endpackage

// File: rtl/rpwm_frame_fsm.sv
module rpwm_frame_fsm
    import rpwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    output logic [POS_W-1:0] pos,
    output logic             last
);
    phase_t phase, phase_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase <= PH_0;
        else
            phase <= phase_nx;
    end

    always_comb begin
        unique case (phase)
            PH_0: phase_nx = PH_1;
            PH_1: phase_nx = PH_2;
            PH_2: phase_nx = PH_3;
            PH_3: phase_nx = PH_4;
            PH_4: phase_nx = PH_5;
            PH_5: phase_nx = PH_6;
            PH_6: phase_nx = PH_7;
            PH_7: phase_nx = PH_0;
            default: phase_nx = PH_0;
        endcase
    end

    always_comb begin
        last = (phase == PH_7);
        pos  = phase;
    end

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> !last); // R2
endmodule

// File: rtl/rpwm_lfsr.sv
module rpwm_lfsr #(
    parameter int            W     = 16,
    parameter logic [W-1:0]  SEED  = 16'hACE1,
    parameter logic [W-1:0]  TAPS  = 16'hB400,
    parameter int            OUT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [OUT_W-1:0] low_next
);
    logic [W-1:0] state, state_nx;
    logic         fb;

    always_comb begin
        fb       = ^(state & TAPS);
        state_nx = {state[W-2:0], fb};
        low_next = state_nx[OUT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= SEED;
        else if (advance)
            state <= state_nx;
    end

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0); // R7
    AST_LFSR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(state)); // R7
endmodule

// File: rtl/rpwm_pattern.sv
module rpwm_pattern
    import rpwm_pkg::*;
(
    input  logic [POS_W-1:0] pos,
    input  level_t           level,
    input  logic [POS_W-1:0] offset,
    output logic             bit_val
);
    logic [POS_W-1:0] rel;

    always_comb begin
        rel     = pos - offset;
        bit_val = (level_t'(rel) < level);
    end
endmodule

// File: rtl/rpwm_serializer.sv
module rpwm_serializer
    import rpwm_pkg::*;
#(
    parameter int               LFSR_W    = 16,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             code_valid,
    input  logic [LVL_W-1:0] code,
    input  logic             restrict_en,
    input  logic             rotate_en,
    output logic             bit_out,
    output logic             frame_strobe
);
    logic [POS_W-1:0] pos;
    logic             last;
    logic [POS_W-1:0] rot_next;
    level_t           level_q;
    logic [POS_W-1:0] offset_q;
    logic             rot_q;
    logic             restrict_q;
    level_t           ones_acc;

    rpwm_frame_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .pos   (pos),
        .last  (last)
    );

    rpwm_lfsr #(
        .W     (LFSR_W),
        .SEED  (LFSR_SEED),
        .TAPS  (LFSR_TAPS),
        .OUT_W (POS_W)
    ) u_lfsr (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (last),
        .low_next (rot_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q    <= '0;
            offset_q   <= '0;
            rot_q      <= 1'b0;
            restrict_q <= 1'b0;
        end else if (last) begin
            if (code_valid) begin
                level_q    <= clamp_level(code, restrict_en);
                restrict_q <= restrict_en;
            end
            rot_q    <= rotate_en;
            offset_q <= rotate_en ? rot_next : '0;
        end
    end

    rpwm_pattern u_pat (
        .pos     (pos),
        .level   (level_q),
        .offset  (offset_q),
        .bit_val (bit_out)
    );

    assign frame_strobe = last;

    // running count of emitted ones, for the frame-level check
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ones_acc <= '0;
        else if (last)
            ones_acc <= '0;
        else
            ones_acc <= ones_acc + level_t'(bit_out);
    end

    AST_FRAME_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        last |-> ((ones_acc + level_t'(bit_out)) == level_q)); // R3
    AST_HOLD_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !last |=> $stable(level_q)); // R4
    AST_RESTRICT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        restrict_q |-> (level_q >= level_t'(1) && level_q <= level_t'(LVL_MAX - 1))); // R5
    AST_NOROT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (!rot_q && pos != '0 && bit_out) |-> $past(bit_out)); // R6
    AST_EDGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (restrict_q && !rot_q && pos == '0) |-> bit_out); // R8
endmodule

// File: tb/rpwm_serializer_test.sv
module rpwm_serializer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       code_valid = 1'b0;
    logic [3:0] code = 4'd0;
    logic       restrict_en = 1'b0;
    logic       rotate_en = 1'b0;
    logic       bit_out;
    logic       frame_strobe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model state
    int          m_pos = 0;
    int          m_lvl = 0;
    int          m_off = 0;
    bit          m_rot = 1'b0;
    bit          m_rest = 1'b0;
    logic [15:0] m_lfsr = 16'hACE1;
    int          ones_seen = 0;
    string       m_tag = "R1";

    rpwm_serializer uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .code_valid   (code_valid),
        .code         (code),
        .restrict_en  (restrict_en),
        .rotate_en    (rotate_en),
        .bit_out      (bit_out),
        .frame_strobe (frame_strobe)
    );

    always #10 clk = ~clk;

    function automatic logic [15:0] lfsr_adv(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic int exp_level(input int c, input bit r);
        int v;
        v = (c > 8) ? 8 : c;
        if (r && v == 0) v = 1;
        if (r && v == 8) v = 7;
        return v;
    endfunction

    task automatic check_int(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (pos %0d)", tag, act, exp, m_pos);
        end
    endtask

    // called at a falling edge; checks, drives inputs, advances model, waits one cycle
    task automatic step(input bit v, input int c, input bit r, input bit o, input string tag);
        int  eb;
        eb = (((m_pos - m_off) & 7) < m_lvl) ? 1 : 0;
        check_int(int'(bit_out), eb, m_rot ? "R7" : "R6");
        check_int(int'(frame_strobe), (m_pos == 7) ? 1 : 0, (m_tag == "R1") ? "R1" : "R2");
        if (m_rest && !m_rot && m_pos == 0) check_int(int'(bit_out), 1, "R8");
        if (m_rest && !m_rot && m_pos == 7) check_int(int'(bit_out), 0, "R8");
        if (m_pos == 7) begin
            check_int(ones_seen + int'(bit_out), m_lvl, m_tag);
            ones_seen = 0;
            code_valid  = v;
            code        = 4'(c);
            restrict_en = r;
            rotate_en   = o;
            m_lfsr = lfsr_adv(m_lfsr);
            if (v) begin
                m_lvl  = exp_level(c, r);
                m_rest = r;
            end
            m_rot = o;
            m_off = o ? int'(m_lfsr[2:0]) : 0;
            m_tag = tag;
        end else begin
            ones_seen += int'(bit_out);
            code_valid  = 1'($urandom);
            code        = 4'($urandom);
            restrict_en = 1'($urandom);
            rotate_en   = 1'($urandom);
        end
        m_pos = (m_pos + 1) & 7;
        @(negedge clk);
    endtask

    task automatic run_frame(input bit v, input int c, input bit r, input bit o, input string tag);
        for (int i = 0; i < 8; i++) step(v, c, r, o, tag);
    endtask

    initial begin
        void'($urandom(32'h1F2E3D4C));
        repeat (3) @(negedge clk);
        checks++;
        if (bit_out !== 1'b0 || frame_strobe !== 1'b0) begin
            errors++;
            $display("FAIL R1: actual %b%b expected 00 in reset", bit_out, frame_strobe);
        end
        rst_n = 1'b1;
        check_int(int'(bit_out), 0, "R1");
        check_int(int'(frame_strobe), 0, "R1");
        // frame 0 (reset level) then all codes without rotation
        for (int c = 0; c < 16; c++) run_frame(1'b1, c, 1'b0, 1'b0, "R3");
        // hold: no valid code at the boundary
        run_frame(1'b1, 5, 1'b0, 1'b0, "R3");
        run_frame(1'b0, 2, 1'b0, 1'b0, "R4");
        run_frame(1'b0, 7, 1'b1, 1'b0, "R4");
        // restricted levels, no rotation
        run_frame(1'b1, 0, 1'b1, 1'b0, "R5");
        run_frame(1'b1, 8, 1'b1, 1'b0, "R5");
        run_frame(1'b1, 13, 1'b1, 1'b0, "R5");
        run_frame(1'b1, 3, 1'b1, 1'b0, "R5");
        run_frame(1'b0, 0, 1'b0, 1'b0, "R4");
        // rotation corner cases
        run_frame(1'b1, 8, 1'b0, 1'b1, "R3");
        run_frame(1'b1, 0, 1'b0, 1'b1, "R3");
        run_frame(1'b1, 1, 1'b0, 1'b1, "R3");
        run_frame(1'b1, 7, 1'b1, 1'b1, "R5");
        // constrained random
        for (int f = 0; f < 400; f++)
            run_frame(1'($urandom), int'($urandom_range(0, 15)), 1'($urandom),
                      1'($urandom), "R3");
        run_frame(1'b1, 4, 1'b0, 1'b0, "R3");
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule